// File: doc/BRIEF.md
# Cascaded Backplane Phase Synchronizer

This block keeps the backplane multiplex phase of one display-driver device aligned with the other devices of a cascade. A frame-timing strobe steps a phase counter through the active backplane phases of the selected multiplex mode. When the counter enters the final active phase, the block raises an output-enable that pulls a shared sync line low. The line is active-low, open-drain with a pull-up, and wired-AND across all devices.

In every other phase the block does not drive the line; it only listens. It passes the sensed level through a two-stage synchronizer. If it sees the line low while it has not recently driven it, it jumps its phase counter straight to the final active phase. As a result, whichever device reaches its final phase first sets the phase of the whole cascade. The block ignores the echo of its own drive for as long as that echo takes to clear the synchronizer.

Top module: `bp_phase_sync`

## Requirements
- R1: An active-low reset sets the phase index to 0. During reset the synchronizer reads the line as released (high).
- R2: On each one-cycle strobe, a phase index below the last active phase advances by one in the following cycle. Without a strobe or a re-align, the index holds its value.
- R3: The mode code selects the last active phase: 0 is static (last phase 0), 1 is 1:2 (phase 1), 2 is 1:3 (phase 2) and 3 is 1:4 (phase 3). A strobe taken while the index is at or beyond the last active phase returns it to 0, including after a mode change.
- R4: The drive-enable output is high exactly while the phase index equals the last active phase. It is therefore raised in the cycle after the strobe that enters that phase and stays up until the strobe that leaves it.
- R5: The sensed line (low = asserted) goes through two flip-flops. If the line is low at a clock edge and the block is not masking its own drive, the phase index shows the last active phase after the third rising edge, counting that first edge.
- R6: Low line levels are ignored during the block's own drive and for the two cycles after it ends. Its own echo never moves the phase index.
- R7: When a re-align and a strobe fall in the same cycle, the re-align wins and the index goes to the last active phase.
- R8: Four instances sharing one strobe, one mode and one wired-AND line recover from one instance gaining or missing a strobe. After one frame of common strobes, all phase indices are equal.
- R9: A line held high has no effect: the phase index changes only on strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseStrobe | input | 1 | One-cycle frame-timing strobe that steps the phase |
| muxMode | input | PHASE_W | Multiplex mode code; equals the last active phase index |
| syncLineIn | input | 1 | Sensed level of the shared sync line, low when asserted |
| phaseIdx | output | PHASE_W | Current backplane phase index |
| syncDriveEn | output | 1 | High to pull the shared sync line low |

## Verification
The bench sweeps every mode on a looped-back instance. After each strobe it waits past the synchronizer latency, so a design that forgot to mask its own echo would jump back to the last phase right after wrapping. It times a one-cycle external pull to the exact edge where the index must change. This catches an extra or missing synchronizer stage, and a strobe placed on that same edge catches a design that lets the strobe override the re-align. A four-instance cascade is knocked out of step at every phase position, once by an extra strobe and once by a missed one. A design that re-aligned to the wrong phase, or only on one side of the drift, would leave the indices unequal after a frame.

// File: rtl/bps_pkg.sv
package bps_pkg;

  // Strobes issued by the control to the phase datapath; at most one is high.
  typedef struct packed {
    logic advance;
    logic wrap;
    logic realign;
  } phaseCmd_t;

endpackage

// File: rtl/bps_datapath.sv
module bps_datapath
  import bps_pkg::*;
#(
  parameter int PHASE_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  phaseCmd_t          cmd,
  input  logic [PHASE_W-1:0] lastPhase,
  input  logic               syncLineIn,
  input  logic               driveEn,
  output logic [PHASE_W-1:0] phase,
  output logic               lineLow,
  output logic               ownMask
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;
  localparam logic [PHASE_W-1:0] PHASE_ZERO = '0;
  localparam logic [PHASE_W-1:0] PHASE_ONE  = PHASE_W'(1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [SYNC_STAGES-1:0] drvHist;

  // Synchronizer chain; idles at the released (high) line level.
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            syncQ[s]   <= 1'b1;
            drvHist[s] <= 1'b0;
          end else begin
            syncQ[s]   <= syncLineIn;
            drvHist[s] <= driveEn;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            syncQ[s]   <= 1'b1;
            drvHist[s] <= 1'b0;
          end else begin
            syncQ[s]   <= syncQ[s-1];
            drvHist[s] <= drvHist[s-1];
          end
        end
      end
    end
  endgenerate

  assign lineLow = ~syncQ[LAST_STAGE];
  // Own drive is still in flight through the synchronizer for SYNC_STAGES cycles.
  assign ownMask = driveEn | (|drvHist);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PHASE_ZERO;
    end else if (cmd.realign) begin
      phase <= lastPhase;
    end else if (cmd.wrap) begin
      phase <= PHASE_ZERO;
    end else if (cmd.advance) begin
      phase <= phase + PHASE_ONE;
    end
  end

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrap |=> phase == PHASE_ZERO);

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.advance |=> phase == $past(phase) + PHASE_ONE);

  assert_realign_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.realign |=> phase == $past(lastPhase));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.advance || cmd.wrap || cmd.realign) |=> $stable(phase));

endmodule

// File: rtl/bps_ctrl.sv
module bps_ctrl
  import bps_pkg::*;
#(
  parameter int PHASE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               phaseStrobe,
  input  logic [PHASE_W-1:0] lastPhase,
  input  logic [PHASE_W-1:0] phase,
  input  logic               lineLow,
  input  logic               ownMask,
  output phaseCmd_t          cmd,
  output logic               driveEn
);

  logic atLast;
  logic atOrBeyond;
  logic pulledByPeer;

  always_comb begin
    atLast       = (phase == lastPhase);
    atOrBeyond   = (phase >= lastPhase);
    pulledByPeer = lineLow & ~ownMask;
    driveEn      = atLast;

    cmd          = '0;
    // Re-align outranks the strobe so a peer's assertion is never lost.
    cmd.realign  = pulledByPeer;
    cmd.wrap     = phaseStrobe & ~pulledByPeer & atOrBeyond;
    cmd.advance  = phaseStrobe & ~pulledByPeer & ~atOrBeyond;
  end

  assert_drive_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && !phaseStrobe) |=> (driveEn || !$stable(lastPhase)));

endmodule

// File: rtl/bp_phase_sync.sv
module bp_phase_sync
  import bps_pkg::*;
#(
  parameter int PHASE_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               phaseStrobe,
  input  logic [PHASE_W-1:0] muxMode,
  input  logic               syncLineIn,
  output logic [PHASE_W-1:0] phaseIdx,
  output logic               syncDriveEn
);

  phaseCmd_t          cmd;
  logic [PHASE_W-1:0] phase;
  logic               lineLow;
  logic               ownMask;
  logic               driveEn;

  bps_ctrl #(.PHASE_W(PHASE_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .phaseStrobe (phaseStrobe),
    .lastPhase   (muxMode),
    .phase       (phase),
    .lineLow     (lineLow),
    .ownMask     (ownMask),
    .cmd         (cmd),
    .driveEn     (driveEn)
  );

  bps_datapath #(.PHASE_W(PHASE_W), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .lastPhase  (muxMode),
    .syncLineIn (syncLineIn),
    .driveEn    (driveEn),
    .phase      (phase),
    .lineLow    (lineLow),
    .ownMask    (ownMask)
  );

  assign phaseIdx    = phase;
  assign syncDriveEn = driveEn;

  assert_release_on_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(syncDriveEn) && $stable(muxMode)) |-> $past(phaseStrobe));

endmodule

// File: tb/sim_bp_phase_sync.sv
module sim_bp_phase_sync;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN;
  logic       stb0;
  logic [1:0] mode0;
  logic       extLine;
  logic       loopOn;
  logic [1:0] ph0;
  logic       drv0;
  wire        line0 = loopOn ? ~drv0 : extLine;

  bp_phase_sync u0 (
    .clk(clk), .rstN(rstN), .phaseStrobe(stb0), .muxMode(mode0),
    .syncLineIn(line0), .phaseIdx(ph0), .syncDriveEn(drv0)
  );

  logic [3:0] casStb;
  logic [1:0] casMode;
  logic [3:0] casDrv;
  logic [1:0] casPh [4];
  wire        casLine = ~|casDrv;

  generate
    for (genvar g = 0; g < 4; g++) begin : casG
      bp_phase_sync uC (
        .clk(clk), .rstN(rstN), .phaseStrobe(casStb[g]), .muxMode(casMode),
        .syncLineIn(casLine), .phaseIdx(casPh[g]), .syncDriveEn(casDrv[g])
      );
    end
  endgenerate

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse0();
    stb0 = 1'b1;
    cyc(1);
    stb0 = 1'b0;
  endtask

  task automatic casPulse(input logic [3:0] mask);
    casStb = mask;
    cyc(1);
    casStb = 4'h0;
    cyc(7);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic checkCascadeEqual(input string req);
    for (int i = 1; i < 4; i++) begin
      check(req, int'(casPh[i]), int'(casPh[0]));
      check(req, int'(casDrv[i]), int'(casDrv[0]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ep;
    rstN = 1'b0; stb0 = 1'b0; mode0 = 2'd3; extLine = 1'b1; loopOn = 1'b0;
    casStb = 4'h0; casMode = 2'd3;
    cyc(1);
    doReset();
    check("R1 reset phase", int'(ph0), 0);
    check("R1 reset drive", int'(drv0), 0);

    // Mode sweep with own drive looped back onto the line
    for (int m = 0; m < 4; m++) begin
      mode0 = 2'(m);
      loopOn = 1'b1;
      doReset();
      check("R1 phase after reset", int'(ph0), 0);
      ep = 0;
      for (int k = 0; k < 2 * (m + 1) + 2; k++) begin
        pulse0();
        ep = (ep >= m) ? 0 : ep + 1;
        check("R2/R3 phase after strobe", int'(ph0), ep);
        check("R4 drive level", int'(drv0), (ep == m) ? 1 : 0);
        cyc(5);
        check("R6 own echo ignored", int'(ph0), ep);
      end
    end

    // R9: released line, no strobes
    loopOn = 1'b0; extLine = 1'b1; mode0 = 2'd3;
    doReset();
    pulse0();
    pulse0();
    cyc(20);
    check("R9 idle line no effect", int'(ph0), 2);

    // R5: one-cycle external pull, latency of three edges
    extLine = 1'b0;
    cyc(1);
    extLine = 1'b1;
    check("R5 edge1 unchanged", int'(ph0), 2);
    cyc(1);
    check("R5 edge2 unchanged", int'(ph0), 2);
    cyc(1);
    check("R5 edge3 realigned", int'(ph0), 3);
    check("R4 drive after realign", int'(drv0), 1);
    pulse0();
    check("R3 wrap after realign", int'(ph0), 0);
    cyc(4);

    // R7: strobe on the same edge as the re-align
    extLine = 1'b0;
    cyc(1);
    extLine = 1'b1;
    cyc(1);
    stb0 = 1'b1;
    cyc(1);
    stb0 = 1'b0;
    check("R7 realign beats strobe", int'(ph0), 3);

    // R3: mode lowered while beyond the new last phase
    mode0 = 2'd1;
    cyc(1);
    check("R4 no drive beyond last", int'(drv0), 0);
    pulse0();
    check("R3 wrap from beyond", int'(ph0), 0);
    pulse0();
    check("R2 advance after mode change", int'(ph0), 1);

    // R8: cascade knocked out of step at every phase, leading and lagging
    for (int m = 1; m < 4; m++) begin
      for (int off = 0; off <= m; off++) begin
        for (int lag = 0; lag < 2; lag++) begin
          casMode = 2'(m);
          doReset();
          checkCascadeEqual("R8 aligned after reset");
          for (int k = 0; k < off; k++) casPulse(4'hF);
          if (lag == 0) casPulse(4'h1 << (off % 4));
          else          casPulse(4'hF & ~(4'h1 << (off % 4)));
          for (int k = 0; k <= m; k++) casPulse(4'hF);
          checkCascadeEqual("R8 aligned after one frame");
          casPulse(4'hF);
          checkCascadeEqual("R8 lockstep after recovery");
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule